// File: doc/BRIEF.md
# Sequential Three-Code Lock

The block is a synchronous lock controller that must see a set of code values in a fixed order before it opens. The user places a value on the code bus and confirms it with a one-cycle enter pulse. The value is judged in that same cycle. Only a full run of correct values, each with its own enter, takes the lock output low. A later enter closes the lock again and the sequence starts over from the first code.

A wrong value at any step moves the controller to an error state and adds one to a failure tally. The tally counts once for each visit to the error state, however long the controller stays there. The next enter acknowledges the error and goes back to the first step. When the tally has reached its limit, that enter leads instead to a dead state. The dead state ignores every input until reset. A successful opening clears the tally.

The codes, the code width, the number of steps and the failure limit are parameters. The defaults are a 4-bit bus, three steps with the values 0xA, 0x2 and 0x7 in that order, and a limit of three failures. A parameter can tie the lockout flag to zero.

Top module: `seq_code_lock`

## Requirements
- R1: While rst (synchronous, active high) is sampled high, the next clock edge sets locked=1 and lockout=0, clears the failure tally and selects the first step.
- R2: With the default parameters, enter pulses with code values 0xA, then 0x2, then 0x7 take locked to 0 after the edge that samples the third enter. Idle cycles between the steps are allowed.
- R3: A cycle with enter low changes neither output nor internal state, whatever value is on the code bus.
- R4: Once open, the lock stays open (locked=0) until an enter pulse arrives, whatever the code value. That pulse sets locked=1 and returns to the first step.
- R5: A wrong value at any step goes to the error state with locked=1. The next enter, whatever the code, returns to the first step, unless the failure limit has been reached.
- R6: Correct values given in the wrong order count as a wrong entry.
- R7: When the third failure (MAX_FAILS) has been acknowledged by an enter, lockout goes to 1 and locked stays at 1. After that, no input sequence changes either output until reset.
- R8: The failure tally goes up once per entry into the error state. Extra cycles spent in that state do not add to it.
- R9: A successful opening clears the failure tally.
- R10: Reset brings the block out of lockout, and a correct sequence opens it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W | Code value, judged in the cycle that enter is high |
| enter | input | 1 | One-cycle confirm pulse |
| locked | output | 1 | 1 = locked, 0 = open (Moore output) |
| lockout | output | 1 | 1 = permanent lockout until reset (constant 0 when HAS_LOCKOUT=0) |

## Verification
The correct sequence is applied with and without idle cycles, and with code values that change while enter is low. This shows that only the enter cycles are sampled. Wrong values are given at the first and the last step and as an out-of-order sequence. After each of these, a full correct sequence checks that control went back to the first step. A long stay in the error state, followed by a run that still opens, tells a per-entry count apart from a per-cycle count. Two failures before and two after an opening show that the opening cleared the tally. A correct sequence after lockout, and another after reset, shows that the lockout holds and that reset releases it.

// File: rtl/lock_pkg.sv
package lock_pkg;
   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_OPEN    = 2'd1,
      ST_WRONG   = 2'd2,
      ST_DEAD    = 2'd3
   } lock_st_e;
endpackage

// File: rtl/code_table.sv
module code_table #(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned NUM_STEPS = 3,
   parameter int unsigned IDX_W     = 2,
   parameter logic [NUM_STEPS*CODE_W-1:0] CODE_SEQ = '0
) (
   input  logic [IDX_W-1:0]  step_idx,
   input  logic [CODE_W-1:0] code_in,
   output logic              match
);
   logic [NUM_STEPS-1:0] hit;

   for (genvar i = 0; i < NUM_STEPS; i++) begin : g_cmp
      assign hit[i] = (code_in == CODE_SEQ[i*CODE_W +: CODE_W]);
   end

   always_comb begin
      match = 1'b0;
      for (int k = 0; k < NUM_STEPS; k++) begin
         if (step_idx == IDX_W'(k)) match = hit[k];
      end
   end
endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
   parameter int unsigned LIMIT = 3,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bump,
   input  logic             clear,
   output logic [CNT_W-1:0] cnt,
   output logic             at_limit
);
   always_ff @(posedge clk) begin
      if (rst)                 cnt <= '0;
      else if (clear)          cnt <= '0;
      else if (bump && !at_limit) cnt <= cnt + CNT_W'(1);
   end

   assign at_limit = (cnt == CNT_W'(LIMIT));

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      at_limit && !clear |=> at_limit); // R7
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
   import lock_pkg::*;
#(
   parameter int unsigned NUM_STEPS = 3,
   parameter int unsigned IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enter,
   input  logic             match,
   input  logic             at_limit,
   output lock_st_e         st_q,
   output logic [IDX_W-1:0] step_q,
   output logic             bump,
   output logic             clear
);
   lock_st_e         st_d;
   logic [IDX_W-1:0] step_d;
   logic             is_last;

   assign is_last = (step_q == IDX_W'(NUM_STEPS - 1));
   assign bump    = (st_q == ST_COLLECT) && enter && !match;
   assign clear   = (st_q == ST_COLLECT) && enter && match && is_last;

   always_comb begin
      st_d   = st_q;
      step_d = step_q;
      unique case (st_q)
         ST_COLLECT: if (enter) begin
            if (!match) begin
               st_d   = ST_WRONG;
               step_d = '0;
            end else if (is_last) begin
               st_d   = ST_OPEN;
               step_d = '0;
            end else begin
               step_d = step_q + IDX_W'(1);
            end
         end
         ST_WRONG: if (enter) begin
            st_d   = at_limit ? ST_DEAD : ST_COLLECT;
            step_d = '0;
         end
         ST_OPEN: if (enter) begin
            st_d   = ST_COLLECT;
            step_d = '0;
         end
         default: begin
            st_d   = ST_DEAD;
            step_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_COLLECT;
         step_q <= '0;
      end else begin
         st_q   <= st_d;
         step_q <= step_d;
      end
   end

   AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (rst)
      st_q == ST_DEAD |=> st_q == ST_DEAD); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !enter |=> (st_q == $past(st_q)) && (step_q == $past(step_q))); // R3
endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
   import lock_pkg::*;
#(
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned NUM_STEPS   = 3,
   parameter logic [NUM_STEPS*CODE_W-1:0] CODE_SEQ = 12'h72A,
   parameter int unsigned MAX_FAILS   = 3,
   parameter bit          HAS_LOCKOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code_in,
   input  logic              enter,
   output logic              locked,
   output logic              lockout
);
   localparam int unsigned IDX_W = $clog2(NUM_STEPS);
   localparam int unsigned CNT_W = $clog2(MAX_FAILS + 1);

   if (CODE_W < 1 || CODE_W > 32) begin : g_bad_width
      $error("seq_code_lock: CODE_W must be 1..32");
   end
   if (NUM_STEPS < 2) begin : g_bad_steps
      $error("seq_code_lock: NUM_STEPS must be at least 2");
   end
   if (MAX_FAILS < 1) begin : g_bad_fails
      $error("seq_code_lock: MAX_FAILS must be at least 1");
   end

   lock_st_e         st_q;
   logic [IDX_W-1:0] step_q;
   logic             match, bump, clear, at_limit;
   logic [CNT_W-1:0] fail_cnt;

   code_table #(
      .CODE_W(CODE_W), .NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W), .CODE_SEQ(CODE_SEQ)
   ) u_table (
      .step_idx(step_q), .code_in(code_in), .match(match)
   );

   fail_counter #(.LIMIT(MAX_FAILS), .CNT_W(CNT_W)) u_fails (
      .clk(clk), .rst(rst), .bump(bump), .clear(clear),
      .cnt(fail_cnt), .at_limit(at_limit)
   );

   lock_fsm #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst(rst), .enter(enter), .match(match), .at_limit(at_limit),
      .st_q(st_q), .step_q(step_q), .bump(bump), .clear(clear)
   );

   assign locked = (st_q != ST_OPEN);

   if (HAS_LOCKOUT) begin : g_flag
      assign lockout = (st_q == ST_DEAD);
      AST_LOCKOUT_FROM_WRONG: assert property (@(posedge clk) disable iff (rst)
         $rose(lockout) |-> ($past(st_q) == ST_WRONG) && $past(at_limit)); // R7
   end else begin : g_noflag
      assign lockout = 1'b0;
   end

   AST_UNLOCK_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> $past(enter) && ($past(step_q) == IDX_W'(NUM_STEPS - 1))); // R2
   AST_WRONG_NO_RECOUNT: assert property (@(posedge clk) disable iff (rst)
      st_q == ST_WRONG |=> (st_q != ST_WRONG) || (fail_cnt == $past(fail_cnt))); // R8
   AST_OPEN_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
      st_q == ST_OPEN |-> fail_cnt == '0); // R9
endmodule

// File: tb/sim_seq_code_lock.sv
module sim_seq_code_lock;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] code_in = 4'h0;
   logic       enter = 1'b0;
   logic       locked, lockout;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct {
      int    due;
      logic  exp_l;
      logic  exp_lo;
      string tag;
   } exp_t;
   exp_t q[$];

   seq_code_lock u0 (
      .clk(clk), .rst(rst), .code_in(code_in), .enter(enter),
      .locked(locked), .lockout(lockout)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare results due at this cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (locked !== e.exp_l || lockout !== e.exp_lo) begin
            bad++;
            $display("FAIL %s: locked=%b lockout=%b expected locked=%b lockout=%b",
                     e.tag, locked, lockout, e.exp_l, e.exp_lo);
         end
      end
   end

   // driver: one cycle of stimulus plus expected outputs after the next edge
   task automatic drive(input logic rs, input logic [3:0] c, input logic e,
                        input logic el, input logic elo, input string tag);
      exp_t it;
      @(posedge clk);
      #2;
      rst = rs; code_in = c; enter = e;
      it.due = cyc + 1; it.exp_l = el; it.exp_lo = elo; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic open_seq(input string tag);
      drive(0, 4'hA, 1, 1, 0, tag);
      drive(0, 4'h2, 1, 1, 0, tag);
      drive(0, 4'h7, 1, 0, 0, tag);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      for (int i = 0; i < 3; i++) drive(1, 4'hA, 1, 1, 0, "R1");
      // R3 codes without enter
      drive(0, 4'hA, 0, 1, 0, "R3");
      drive(0, 4'h2, 0, 1, 0, "R3");
      drive(0, 4'h7, 0, 1, 0, "R3");
      // R2 correct sequence with idle gap
      drive(0, 4'hA, 1, 1, 0, "R2");
      drive(0, 4'h5, 0, 1, 0, "R2");
      drive(0, 4'h2, 1, 1, 0, "R2");
      drive(0, 4'h7, 1, 0, 0, "R2");
      // R4 stays open until enter, then back to first step
      for (int i = 0; i < 3; i++) drive(0, 4'h3, 0, 0, 0, "R4");
      drive(0, 4'hA, 0, 0, 0, "R4");
      drive(0, 4'h0, 1, 1, 0, "R4");
      open_seq("R4");
      drive(0, 4'h0, 1, 1, 0, "R4");
      // R6 out of order (fail 1)
      drive(0, 4'h2, 1, 1, 0, "R6");
      drive(0, 4'h0, 1, 1, 0, "R6");
      // R5 wrong at last step (fail 2), R8 long stay in error state
      drive(0, 4'hA, 1, 1, 0, "R5");
      drive(0, 4'h2, 1, 1, 0, "R5");
      drive(0, 4'h8, 1, 1, 0, "R5");
      for (int i = 0; i < 12; i++) drive(0, 4'h1, 0, 1, 0, "R8");
      drive(0, 4'hA, 1, 1, 0, "R8");
      open_seq("R5");
      drive(0, 4'h0, 1, 1, 0, "R9");
      // R9 opening cleared the tally: two more failures do not lock out
      drive(0, 4'h5, 1, 1, 0, "R9");
      drive(0, 4'h0, 1, 1, 0, "R9");
      drive(0, 4'h5, 1, 1, 0, "R9");
      drive(0, 4'h0, 1, 1, 0, "R9");
      open_seq("R9");
      drive(0, 4'h0, 1, 1, 0, "R9");
      // R7 three failures lead to lockout
      drive(0, 4'h1, 1, 1, 0, "R7");
      drive(0, 4'h0, 1, 1, 0, "R7");
      drive(0, 4'h1, 1, 1, 0, "R7");
      drive(0, 4'h0, 1, 1, 0, "R7");
      drive(0, 4'h1, 1, 1, 0, "R7");
      drive(0, 4'hA, 1, 1, 1, "R7");
      drive(0, 4'hA, 1, 1, 1, "R7");
      drive(0, 4'h2, 1, 1, 1, "R7");
      drive(0, 4'h7, 1, 1, 1, "R7");
      drive(0, 4'h0, 1, 1, 1, "R7");
      drive(0, 4'h3, 0, 1, 1, "R7");
      // R10 reset releases lockout
      drive(1, 4'h0, 0, 1, 0, "R10");
      open_seq("R10");
      drive(0, 4'h0, 0, 0, 0, "R10");
      drive(0, 4'h0, 0, 0, 0, "R10");
      @(posedge clk);
      @(posedge clk);
      if (q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      done = 1'b1;
      finish_run();
   end
endmodule